// File: doc/BRIEF.md
# Four-Copy Voting Memory Front End

This block stands between a processor-side single-word memory bus and four identical synchronous RAM copies. It hides soft errors from the processor. A processor store is written to every copy in the same cycle. All four copies are then read back, and each copy that holds something other than the stored word loses standing and is rewritten. A processor load reads all four copies in parallel. It excludes the copy with the weakest standing, takes a bitwise two-of-three vote over the remaining three, and returns the voted word. Any copy that disagrees with the vote is repaired before the access completes.

Each copy carries a small saturating health grade. A disagreement lowers the grade and an agreement raises it, so a copy that keeps failing stops taking part in votes. When the processor is quiet, the block walks a short list of recently touched addresses and re-votes each one. This cleans up latent upsets before they can pair with a second upset and defeat the vote.

The processor raises a request and holds it until a one-cycle ready pulse. The grades are exposed as a packed status vector.

Top module: `quad_vote_mem`

## Requirements
- R1: A processor write drives the store word onto all four copies with all four write enables high (mem_we = 4'b1111) in the same cycle.
- R2: After that store, the four copies are read back at the same address. A copy that holds a different word has its grade lowered by one and is rewritten with the store word before ready. A copy that holds the store word has its grade raised by one.
- R3: A processor read returns the bitwise two-of-three majority of the three copies that remain after the copy with the lowest grade is left out.
- R4: When several copies share the lowest grade, the one with the highest index is the copy left out.
- R5: On a read or a scrub, every copy whose word differs from the voted word is rewritten with the voted word, and this completes before ready is pulsed for that access.
- R6: Grades are 4-bit saturating counters that reset to 8. They stop at 15 and at 0. Copy i's grade is visible on grade_o bits [4i+3:4i].
- R7: With no request pending, the block re-reads, votes on and repairs recently accessed addresses without any processor action.
- R8: The scrub list holds the four most recently accessed distinct addresses. Accessing a listed address makes it most recent. A new address replaces the least recently accessed entry.
- R9: A request that arrives while a scrub is under way waits until that scrub, including its repair write, has finished. The request is then served. For a read raised in the scrub's read cycle that needs a repair, ready is seen six cycles later.
- R10: ready is a single-cycle pulse. During reset and right after it, ready is low, no memory enable is active and all grades read 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request, held until ready |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Voted load data, valid with ready |
| grade_o | output | 4*GW | Packed grades, copy 0 in the low bits |
| mem_addr | output | AW | Address shared by the four copies |
| mem_re | output | 1 | Read strobe to all copies, data one cycle later |
| mem_we | output | 4 | Per-copy write enable |
| mem_wdata | output | DW | Write data shared by the copies |
| mem_rdata | input | 4*DW | Read data of the four copies, copy 0 in the low bits |

## Verification
The scrub engine and a processor request can meet in the same cycle: a request can land while a scrub read is already on the memory port. The bench watches for a scrub read strobe with no request pending. In that same cycle it corrupts one copy at the scrubbed address and raises a load of that address. The bench then judges the outcome by three things: the number of cycles until ready, the repaired copy, and the correct returned word. Together these show that the scrub ran to completion and was not cut short or merged with the load.

// File: rtl/quad_vote_mem.sv
module quad_vote_mem #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int GW = 4,
  parameter int RECENT = 4,
  parameter logic [GW-1:0] GRADE_RST = 4'd8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic [DW-1:0]   req_rdata,
  output logic [4*GW-1:0] grade_o,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_re,
  output logic [3:0]      mem_we,
  output logic [DW-1:0]   mem_wdata,
  input  logic [4*DW-1:0] mem_rdata
);
  localparam int NC = 4;
  localparam int PW = $clog2(RECENT);
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_CHK, S_WB} state_t;
  state_t st;

  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata, fix_data, rdata_q;
  logic          op_wr, op_scrub, done_q;
  logic [NC-1:0] fix_mask;
  logic [GW-1:0] grade [NC];
  logic [AW-1:0] rec [RECENT];
  logic [RECENT-1:0] rec_v;
  logic [PW-1:0] sp;

  logic [DW-1:0] cp [NC];
  logic [NC-1:0] mism;
  logic [1:0]    worst;
  logic [DW-1:0] va, vb, vc, voted, ref_w;
  logic          hit, accept;
  logic [PW-1:0] hidx, shift_lim;

  for (genvar g = 0; g < NC; g++) begin : g_copy
    assign cp[g] = mem_rdata[g*DW +: DW];
    assign mism[g] = cp[g] != ref_w;
    assign grade_o[g*GW +: GW] = grade[g];
  end

  always_comb begin
    worst = 2'd0;
    for (int i = 1; i < NC; i++)
      if (grade[i] <= grade[worst]) worst = 2'(i);
  end

  always_comb begin
    case (worst)
      2'd0:    begin va = cp[1]; vb = cp[2]; vc = cp[3]; end
      2'd1:    begin va = cp[0]; vb = cp[2]; vc = cp[3]; end
      2'd2:    begin va = cp[0]; vb = cp[1]; vc = cp[3]; end
      default: begin va = cp[0]; vb = cp[1]; vc = cp[2]; end
    endcase
  end

  assign voted = (va & vb) | (va & vc) | (vb & vc);
  assign ref_w = op_wr ? cur_wdata : voted;

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < RECENT; i++)
      if (!hit && rec_v[i] && rec[i] == req_addr) begin
        hit  = 1'b1;
        hidx = PW'(i);
      end
  end

  assign shift_lim = hit ? hidx : PW'(RECENT - 1);
  assign accept    = (st == S_IDLE) && !done_q && req_valid;

  assign mem_addr  = cur_addr;
  assign mem_re    = (st == S_RD);
  assign mem_we    = (st == S_WR) ? 4'hF : (st == S_WB) ? fix_mask : 4'h0;
  assign mem_wdata = (st == S_WR) ? cur_wdata : fix_data;
  assign req_ready = done_q;
  assign req_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done_q    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      fix_data  <= '0;
      rdata_q   <= '0;
      fix_mask  <= '0;
      op_wr     <= 1'b0;
      op_scrub  <= 1'b0;
      rec_v     <= '0;
      sp        <= '0;
      for (int i = 0; i < NC; i++) grade[i] <= GRADE_RST;
      for (int i = 0; i < RECENT; i++) rec[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            op_wr     <= req_write;
            op_scrub  <= 1'b0;
            st        <= req_write ? S_WR : S_RD;
            for (int i = RECENT - 1; i > 0; i--)
              if (PW'(i) <= shift_lim) begin
                rec[i]   <= rec[i-1];
                rec_v[i] <= rec_v[i-1];
              end
            rec[0]   <= req_addr;
            rec_v[0] <= 1'b1;
          end else if (!done_q && !req_valid) begin
            if (rec_v[sp]) begin
              cur_addr <= rec[sp];
              op_wr    <= 1'b0;
              op_scrub <= 1'b1;
              st       <= S_RD;
            end
            sp <= (sp == PW'(RECENT - 1)) ? '0 : sp + 1'b1;
          end
        end
        S_WR: st <= S_RD;
        S_RD: st <= S_CHK;
        S_CHK: begin
          fix_mask <= mism;
          fix_data <= ref_w;
          if (!op_scrub) rdata_q <= ref_w;
          for (int i = 0; i < NC; i++)
            if (mism[i]) begin
              if (grade[i] != '0) grade[i] <= grade[i] - 1'b1;
            end else begin
              if (grade[i] != GMAX) grade[i] <= grade[i] + 1'b1;
            end
          if (|mism) st <= S_WB;
          else begin
            st     <= S_IDLE;
            done_q <= !op_scrub;
          end
        end
        S_WB: begin
          st     <= S_IDLE;
          done_q <= !op_scrub;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_store_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we == 4'hF) |=> (mem_re && mem_addr == $past(mem_addr)));

  assert_repair_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && |mism) |=> (mem_we == $past(mism) && mem_wdata == $past(ref_w)));

  assert_scrub_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_scrub && st == S_RD) |=> (mem_addr == $past(mem_addr) && !req_ready));

  for (genvar g = 0; g < NC; g++) begin : g_chk
    assert_grade_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grade[g] == $past(grade[g])) ||
      (grade[g] > $past(grade[g]) && grade[g] - $past(grade[g]) == 1) ||
      (grade[g] < $past(grade[g]) && $past(grade[g]) - grade[g] == 1));
  end
endmodule

// File: tb/quad_vote_mem_bench.sv
`timescale 1ns/1ps
module quad_vote_mem_bench;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready;
  logic [DW-1:0] req_rdata;
  logic [4*GW-1:0] grade_o;
  logic [AW-1:0] mem_addr;
  logic mem_re;
  logic [3:0] mem_we;
  logic [DW-1:0] mem_wdata;
  logic [4*DW-1:0] rd_q = '0;

  logic [DW-1:0] ram [4][64];
  logic [3:0] drop_wr = 4'h0;
  int full_wr = 0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  quad_vote_mem #(.AW(AW), .DW(DW), .GW(GW)) u_quad_vote_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .grade_o(grade_o), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(rd_q));

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (mem_we[i]) begin
        if (drop_wr[i]) drop_wr[i] <= 1'b0;
        else ram[i][mem_addr] <= mem_wdata;
      end
    if (mem_re)
      for (int i = 0; i < 4; i++) rd_q[i*DW +: DW] <= ram[i][mem_addr];
  end

  always @(negedge clk) if (mem_we == 4'hF) full_wr++;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_ram();
    for (int i = 0; i < 4; i++)
      for (int a = 0; a < 64; a++) ram[i][a] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; drop_wr = 4'h0;
    clear_ram();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk);
      n++;
    end while (!req_ready && n < 60);
    rd = req_rdata;
    req_valid = 1'b0;
    check(req_ready, "R10 ready arrives", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    check(!req_ready, "R10 ready single pulse", {63'd0, req_ready}, 64'd0);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check(!req_ready, "R10 ready low after reset", {63'd0, req_ready}, 64'd0);
    check(mem_we == 4'h0 && !mem_re, "R10 no memory enable after reset", {59'd0, mem_we, mem_re}, 64'd0);
    check(grade_o == 16'h8888, "R6 grades reset to 8", {48'd0, grade_o}, 64'h8888);
  endtask

  task automatic t_store();
    logic [DW-1:0] rd;
    do_reset();
    full_wr = 0;
    do_req(1'b1, 6'd3, 32'hA5A5_0F0F, rd);
    for (int i = 0; i < 4; i++)
      check(ram[i][3] == 32'hA5A5_0F0F, "R1 copy holds store", {32'd0, ram[i][3]}, {32'd0, 32'hA5A5_0F0F});
    check(full_wr >= 1, "R1 all four enables together", 64'(full_wr), 64'd1);
    do_req(1'b0, 6'd3, '0, rd);
    check(rd == 32'hA5A5_0F0F, "R3 clean load", {32'd0, rd}, {32'd0, 32'hA5A5_0F0F});
    do_reset();
    drop_wr = 4'b0100;
    do_req(1'b1, 6'd9, 32'h1234_5678, rd);
    check(ram[2][9] == 32'h1234_5678, "R2 failed copy rewritten", {32'd0, ram[2][9]}, {32'd0, 32'h1234_5678});
    check(grade_o == 16'h9799, "R2 grades after readback", {48'd0, grade_o}, 64'h9799);
  endtask

  task automatic t_tie();
    logic [DW-1:0] rd;
    do_reset();
    ram[0][12] = 32'hCAFE_0001; ram[1][12] = 32'hCAFE_0001;
    ram[2][12] = 32'h0BAD_0002; ram[3][12] = 32'h0BAD_0002;
    do_req(1'b0, 6'd12, '0, rd);
    check(rd == 32'hCAFE_0001, "R4 tie leaves out highest index", {32'd0, rd}, {32'd0, 32'hCAFE_0001});
    check(ram[2][12] == 32'hCAFE_0001 && ram[3][12] == 32'hCAFE_0001, "R5 disagreeing copies repaired",
          {ram[3][12], ram[2][12]}, {32'hCAFE_0001, 32'hCAFE_0001});
    check(grade_o == 16'h7799, "R6 grades after tie vote", {48'd0, grade_o}, 64'h7799);
  endtask

  task automatic t_rank();
    logic [DW-1:0] rd;
    do_reset();
    for (int i = 0; i < 4; i++) ram[i][20] = 32'h0000_BEEF;
    ram[0][20] = 32'hFFFF_0000;
    ram[0][21] = 32'h1111_1111; ram[1][21] = 32'h1111_1111;
    ram[2][21] = 32'h2222_2222; ram[3][21] = 32'h2222_2222;
    do_req(1'b0, 6'd20, '0, rd);
    check(rd == 32'h0000_BEEF, "R3 vote with one bad copy", {32'd0, rd}, {32'd0, 32'h0000_BEEF});
    check(ram[0][20] == 32'h0000_BEEF, "R5 bad copy repaired", {32'd0, ram[0][20]}, {32'd0, 32'h0000_BEEF});
    check(grade_o == 16'h9997, "R6 grade lowered for bad copy", {48'd0, grade_o}, 64'h9997);
    do_req(1'b0, 6'd21, '0, rd);
    check(rd == 32'h2222_2222, "R3 lowest grade left out", {32'd0, rd}, {32'd0, 32'h2222_2222});
    repeat (200) @(negedge clk);
    check(grade_o == 16'hFFFF, "R6 grades saturate at 15", {48'd0, grade_o}, 64'hFFFF);
  endtask

  task automatic t_recent();
    logic [DW-1:0] rd;
    do_reset();
    for (int k = 1; k <= 5; k++) do_req(1'b1, 6'(k), 32'(k) * 32'h1111_1111, rd);
    repeat (4) @(negedge clk);
    ram[1][1] = ~32'h1111_1111; ram[1][2] = ~32'h2222_2222; ram[1][5] = ~32'h5555_5555;
    repeat (80) @(negedge clk);
    check(ram[1][5] == 32'h5555_5555, "R7 idle scrub repairs recent", {32'd0, ram[1][5]}, {32'd0, 32'h5555_5555});
    check(ram[1][2] == 32'h2222_2222, "R7 idle scrub repairs listed", {32'd0, ram[1][2]}, {32'd0, 32'h2222_2222});
    check(ram[1][1] == ~32'h1111_1111, "R8 evicted address untouched", {32'd0, ram[1][1]}, {32'd0, ~32'h1111_1111});
    do_req(1'b0, 6'd2, '0, rd);
    do_req(1'b1, 6'd6, 32'h6666_6666, rd);
    repeat (4) @(negedge clk);
    ram[2][3] = 32'h0; ram[2][4] = 32'h0;
    repeat (80) @(negedge clk);
    check(ram[2][4] == 32'h4444_4444, "R8 retained entry scrubbed", {32'd0, ram[2][4]}, {32'd0, 32'h4444_4444});
    check(ram[2][3] == 32'h0, "R8 least recent entry replaced", {32'd0, ram[2][3]}, 64'd0);
  endtask

  task automatic t_preempt();
    logic [DW-1:0] rd;
    int n = 0, w = 0;
    do_reset();
    do_req(1'b1, 6'd7, 32'h7777_0007, rd);
    do begin
      @(negedge clk);
      w++;
    end while (!(mem_re && !req_valid) && w < 40);
    ram[3][7] = 32'hDEAD_DEAD;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd7;
    do begin
      @(negedge clk);
      n++;
    end while (!req_ready && n < 60);
    rd = req_rdata;
    req_valid = 1'b0;
    check(n == 6, "R9 request waits for scrub to finish", 64'(n), 64'd6);
    check(rd == 32'h7777_0007, "R9 load after scrub", {32'd0, rd}, {32'd0, 32'h7777_0007});
    check(ram[3][7] == 32'h7777_0007, "R9 scrub repair completed", {32'd0, ram[3][7]}, {32'd0, 32'h7777_0007});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_store();
    t_tie();
    t_rank();
    t_recent();
    t_preempt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule